// File: doc/BRIEF.md
# Watchdog Reset Sequencer with Source Detection

This block pairs a software watchdog with a clocked reset sequencer for a chip whose reset line is a shared, active-low, open-drain pad. Software arms the watchdog once after each reset by writing a timeout rate. From then on it must restart the count with a two-byte key sequence. If the count runs out, or software writes the wrong key, the sequencer pulls the pad low. It does the same when the pad is pulled low from outside the chip.

The sequencer holds the pad low for a fixed stretch and then lets go. A fixed time later it samples the synchronized pad level to decide where the reset came from. A high pad means the watchdog caused it. A pad still low means someone outside is holding it. The result sets a reset-source code and the restart address the CPU fetches. The CPU reset output stays high from the first cycle of the drive until the pad is seen high at or after the sample point. Any reset sequence returns the watchdog registers to their defaults.

Because the source is inferred from the pad level, an outside pulse too short to outlast the sample point is reported as a watchdog reset. A slow-rising pad after a watchdog drive is reported as an outside reset.

Top module: `wdog_reset_seq`

## Requirements
- R1: After power-on reset the outputs are pin_drive_n=1, cpu_reset=0, rst_src=2'b00 (power-on), reset_vector=16'hFFFE and pin_sync=1, and the watchdog is disabled.
- R2: A write with reg_sel=0 sets the rate r from reg_wdata[2:0]. For r from 1 to 7, pin_drive_n falls exactly 2^(4+r) clock edges after the write edge. For r=0 the watchdog stays disabled. Only the first such write after any reset takes effect; later ones are ignored.
- R3: While the watchdog is enabled, a write of 8'h55 and then 8'hAA with reg_sel=1 restarts the count. The next expiry comes 2^(4+r) edges after the 8'hAA write edge.
- R4: While the watchdog is enabled, a write with reg_sel=1 of any other value, of 8'hAA not preceded by 8'h55, or of 8'h55 twice starts the reset drive at that write edge. While it is disabled, such writes have no effect.
- R5: Every sequence drives pin_drive_n low for exactly 128 cycles. cpu_reset rises on the same edge the drive starts and stays high throughout the drive.
- R6: 64 edges after the drive is released, the synchronized pad is sampled. High gives rst_src=2'b01 and reset_vector=16'hFFFA, and cpu_reset falls on that same edge. Low gives rst_src=2'b10 and reset_vector=16'hFFFE.
- R7: A low pad level seen on pin_sync starts the same sequence one edge later. If the pad is still low at the sample point, cpu_reset stays high until pin_sync returns high and falls on the following edge. A shorter outside pulse is classified as a watchdog reset.
- R8: After any sequence the watchdog is disabled and its rate register can be written again. Writes made while cpu_reset is high leave no effect.
- R9: pin_sync follows pin_in through two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the rate register, 1 selects the service register |
| reg_wdata | input | 8 | Write data |
| pin_in | input | 1 | Raw level of the reset pad |
| pin_drive_n | output | 1 | Active-low enable of the pad's low driver |
| pin_sync | output | 1 | Pad level after the two-flop synchronizer |
| cpu_reset | output | 1 | Reset to the processor, high during a sequence |
| rst_src | output | 2 | Last reset source: 00 power-on, 01 watchdog, 10 outside |
| reset_vector | output | 16 | Restart address for the last reset |

## Verification
The watchdog results are checked at exact distances. The drive edge is expected 2^(4+r) edges after the rate write or the closing key write. A bad key drives the pad at its own write edge. The pad is released 128 edges after the drive starts, and cpu_reset and the source code change 64 edges after release. For an outside pulse, pin_sync is checked one and two edges after the pad falls, and the drive one edge later. Release after a held pad is checked one edge after pin_sync returns high. The bench drives inputs 1 ns after a rising edge and reads outputs there, so each sample falls after a known count of edges. It models the open-drain pad, including a programmable slow rise, to reach both classification outcomes.

// File: rtl/wdog_rst_pkg.sv
package wdog_rst_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    SRC_POR  = 2'd0,
    SRC_WDOG = 2'd1,
    SRC_EXT  = 2'd2
  } rst_src_t;

  localparam logic SEL_RATE = 1'b0;
  localparam logic SEL_SVC  = 1'b1;

endpackage

// File: rtl/wdog_pin_sync.sv
module wdog_pin_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_rst_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter int               RATE_W     = 3,
  parameter int               BASE_SHIFT = 4,
  parameter logic [DATA_W-1:0] KEY_ARM   = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              trip
);

  localparam int CNT_W = BASE_SHIFT + (1 << RATE_W);

  logic [RATE_W-1:0] rate_q;
  logic              locked_q;
  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;

  logic             enabled;
  logic             wr_rate;
  logic             wr_svc;
  logic             key_arm_ok;
  logic             key_fire_ok;
  logic [CNT_W-1:0] cnt_last;

  always_comb begin
    enabled     = |rate_q;
    wr_rate     = wr_en && (wr_sel == SEL_RATE);
    wr_svc      = wr_en && (wr_sel == SEL_SVC);
    key_arm_ok  = (wr_data == KEY_ARM) && !armed_q;
    key_fire_ok = (wr_data == KEY_FIRE) && armed_q;
    cnt_last    = (CNT_W'(1) << (BASE_SHIFT + int'(rate_q))) - CNT_W'(1);
    trip        = enabled &&
                  ((cnt_q == cnt_last) || (wr_svc && !key_arm_ok && !key_fire_ok));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rate_q   <= '0;
      locked_q <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (wr_rate && !locked_q) begin
      rate_q   <= wr_data[RATE_W-1:0];
      locked_q <= 1'b1;
      cnt_q    <= '0;
    end else if (enabled) begin
      if (wr_svc && key_fire_ok) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        if (wr_svc && key_arm_ok) begin
          armed_q <= 1'b1;
        end
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/wdog_seq_fsm.sv
module wdog_seq_fsm
  import wdog_rst_pkg::*;
#(
  parameter int               DRIVE_CYC  = 128,
  parameter int               SAMPLE_CYC = 64,
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] VEC_WDOG   = 16'hFFFA,
  parameter logic [VEC_W-1:0] VEC_EXT    = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_lvl,
  input  logic             trip,
  output logic             pin_drive_n,
  output logic             cpu_reset,
  output logic [VEC_W-1:0] vector,
  output logic [1:0]       src
);

  localparam int LONGEST = (DRIVE_CYC > SAMPLE_CYC) ? DRIVE_CYC : SAMPLE_CYC;
  localparam int TW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  seq_st_t   st_q;
  rst_src_t  src_q;
  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RUN;
      tcnt_q      <= '0;
      pin_drive_n <= 1'b1;
      cpu_reset   <= 1'b0;
      vector      <= VEC_EXT;
      src_q       <= SRC_POR;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (trip || !pin_lvl) begin
            st_q        <= ST_DRIVE;
            tcnt_q      <= '0;
            pin_drive_n <= 1'b0;
            cpu_reset   <= 1'b1;
          end
        end
        ST_DRIVE: begin
          if (tcnt_q == TW'(DRIVE_CYC - 1)) begin
            st_q        <= ST_WAIT;
            tcnt_q      <= '0;
            pin_drive_n <= 1'b1;
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        ST_WAIT: begin
          if (tcnt_q == TW'(SAMPLE_CYC - 1)) begin
            tcnt_q <= '0;
            if (pin_lvl) begin
              src_q     <= SRC_WDOG;
              vector    <= VEC_WDOG;
              cpu_reset <= 1'b0;
              st_q      <= ST_RUN;
            end else begin
              src_q  <= SRC_EXT;
              vector <= VEC_EXT;
              st_q   <= ST_HOLD;
            end
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        ST_HOLD: begin
          if (pin_lvl) begin
            st_q      <= ST_RUN;
            cpu_reset <= 1'b0;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign src = src_q;

endmodule

// File: rtl/wdog_reset_seq.sv
module wdog_reset_seq
  import wdog_rst_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               RATE_W      = 3,
  parameter int               BASE_SHIFT  = 4,
  parameter int               DRIVE_CYC   = 128,
  parameter int               SAMPLE_CYC  = 64,
  parameter int               SYNC_STAGES = 2,
  parameter int               VEC_W       = 16,
  parameter logic [DATA_W-1:0] KEY_ARM    = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE   = 8'hAA,
  parameter logic [VEC_W-1:0] VEC_WDOG    = 16'hFFFA,
  parameter logic [VEC_W-1:0] VEC_EXT     = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              pin_in,
  output logic              pin_drive_n,
  output logic              pin_sync,
  output logic              cpu_reset,
  output logic [1:0]        rst_src,
  output logic [VEC_W-1:0]  reset_vector
);

  logic wr_ok;
  logic wd_trip;

  assign wr_ok = reg_wr && !cpu_reset;

  wdog_pin_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE   (1'b1)
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  wdog_core #(
    .DATA_W     (DATA_W),
    .RATE_W     (RATE_W),
    .BASE_SHIFT (BASE_SHIFT),
    .KEY_ARM    (KEY_ARM),
    .KEY_FIRE   (KEY_FIRE)
  ) i_core (
    .clk     (clk),
    .rst     (rst),
    .clr     (cpu_reset),
    .wr_en   (wr_ok),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .trip    (wd_trip)
  );

  wdog_seq_fsm #(
    .DRIVE_CYC  (DRIVE_CYC),
    .SAMPLE_CYC (SAMPLE_CYC),
    .VEC_W      (VEC_W),
    .VEC_WDOG   (VEC_WDOG),
    .VEC_EXT    (VEC_EXT)
  ) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .pin_lvl     (pin_sync),
    .trip        (wd_trip),
    .pin_drive_n (pin_drive_n),
    .cpu_reset   (cpu_reset),
    .vector      (reset_vector),
    .src         (rst_src)
  );

endmodule

// File: rtl/wdog_reset_seq_chk.sv
module wdog_reset_seq_chk #(
  parameter int               DRIVE_CYC = 128,
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] VEC_WDOG  = 16'hFFFA,
  parameter logic [VEC_W-1:0] VEC_EXT   = 16'hFFFE
) (
  input logic             clk,
  input logic             rst,
  input logic             pin_drive_n,
  input logic             cpu_reset,
  input logic [1:0]       rst_src,
  input logic [VEC_W-1:0] vector
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || pin_drive_n) begin
      low_run <= '0;
    end else begin
      low_run <= low_run + 16'd1;
    end
  end

  // R5
  drive_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_drive_n) |-> (low_run == 16'(DRIVE_CYC)));

  // R5
  drive_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_drive_n |-> cpu_reset);

  // R5
  reset_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_reset) |-> !pin_drive_n);

  // R6
  release_classified_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_reset) |-> (pin_drive_n && (rst_src != 2'd0)));

  // R6
  wdog_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_src == 2'd1) |-> (vector == VEC_WDOG));

  // R6
  ext_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_src == 2'd2) |-> (vector == VEC_EXT));

  // R1
  src_code_chk: assert property (@(posedge clk) disable iff (rst)
    rst_src != 2'd3);

endmodule

bind wdog_reset_seq wdog_reset_seq_chk #(
  .DRIVE_CYC (DRIVE_CYC),
  .VEC_W     (VEC_W),
  .VEC_WDOG  (VEC_WDOG),
  .VEC_EXT   (VEC_EXT)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .pin_drive_n (pin_drive_n),
  .cpu_reset   (cpu_reset),
  .rst_src     (rst_src),
  .vector      (reset_vector)
);

// File: tb/test_wdog_reset_seq.sv
`timescale 1ns/1ps
module test_wdog_reset_seq;

  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        ext_low = 1'b0;
  int          cap_delay = 0;
  int          rise_cnt = 0;
  logic        pin_in;
  logic        pin_drive_n;
  logic        pin_sync;
  logic        cpu_reset;
  logic [1:0]  rst_src;
  logic [15:0] reset_vector;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  assign pin_in = pin_drive_n && !ext_low && (rise_cnt == 0);

  always @(negedge clk) begin
    if (!pin_drive_n) rise_cnt <= cap_delay;
    else if (rise_cnt > 0) rise_cnt <= rise_cnt - 1;
  end

  wdog_reset_seq i_wdog_reset_seq (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .pin_in       (pin_in),
    .pin_drive_n  (pin_drive_n),
    .pin_sync     (pin_sync),
    .cpu_reset    (cpu_reset),
    .rst_src      (rst_src),
    .reset_vector (reset_vector)
  );

  function automatic int tmo(input int r);
    return 1 << (BASE + r);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] data);
    @(posedge clk);
    #1;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
  endtask

  // Called 1 ns after the edge that starts the timeout; walks the sequence.
  task automatic run_seq(input int exp_to, input string req, input int exp_src);
    int k = 0;
    int d = 1;
    int w = 0;
    while (pin_drive_n && k < exp_to + 20) begin
      step(1); k++;
    end
    chk(k == exp_to, req, "edges to drive", k, exp_to);
    chk(cpu_reset == 1'b1, "R5", "cpu_reset at drive start", cpu_reset, 1);
    while (d < 400) begin
      step(1);
      if (!pin_drive_n) d++;
      else break;
    end
    chk(d == 128, "R5", "drive length", d, 128);
    while (cpu_reset && w < 600) begin
      step(1); w++;
    end
    if (exp_src == 1) begin
      chk(w == 64, "R6", "release after drive", w, 64);
      chk(rst_src == 2'd1, "R6", "source watchdog", rst_src, 1);
      chk(reset_vector == 16'hFFFA, "R6", "vector watchdog", reset_vector, 16'hFFFA);
    end else begin
      chk(w > 64, "R6", "held past sample", w, 65);
      chk(rst_src == 2'd2, "R6", "source outside", rst_src, 2);
      chk(reset_vector == 16'hFFFE, "R6", "vector outside", reset_vector, 16'hFFFE);
    end
  endtask

  task automatic no_drive(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (!pin_drive_n || cpu_reset) seen = 1'b1;
    end
    chk(!seen, req, "no reset seen", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int r;
    int to;
    logic [7:0] bad;
    void'($urandom(32'd1234));
    step(5);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk(pin_drive_n == 1'b1, "R1", "pin_drive_n", pin_drive_n, 1);
    chk(cpu_reset == 1'b0, "R1", "cpu_reset", cpu_reset, 0);
    chk(rst_src == 2'd0, "R1", "rst_src", rst_src, 0);
    chk(reset_vector == 16'hFFFE, "R1", "reset_vector", reset_vector, 16'hFFFE);
    chk(pin_sync == 1'b1, "R1", "pin_sync", pin_sync, 1);

    // R4: service write while disabled is ignored; R1 watchdog disabled
    wr(1'b1, 8'h13);
    no_drive(60, "R4");

    // R2: write-once rate register, second write ignored
    wr(1'b0, 8'h07);
    wr(1'b0, 8'h01);
    run_seq(tmo(7) - 2, "R2", 1);

    // R8: disabled after watchdog sequence
    no_drive(tmo(7) + 50, "R8");
    // R8: rate register writable again
    wr(1'b0, 8'h01);
    run_seq(tmo(1), "R8", 1);

    // R3: random service trials
    for (int t = 0; t < 6; t++) begin
      r  = $urandom_range(1, 7);
      to = tmo(r);
      wr(1'b0, 8'(r));
      for (int s = 0, n = $urandom_range(1, 4); s < n; s++) begin
        step($urandom_range(0, to / 4));
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
      end
      run_seq(to, "R3", 1);
    end

    // R4: bad key values
    for (int t = 0; t < 3; t++) begin
      do bad = 8'($urandom_range(0, 255));
      while (bad == 8'h55 || bad == 8'hAA);
      wr(1'b0, 8'h02);
      wr(1'b1, bad);
      run_seq(0, "R4", 1);
    end
    wr(1'b0, 8'h03);
    wr(1'b1, 8'hAA);
    run_seq(0, "R4", 1);
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h55);
    run_seq(0, "R4", 1);

    // R8: write during sequence leaves no effect
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h00);
    chk(pin_drive_n == 1'b0, "R4", "drive on bad key", pin_drive_n, 0);
    wr(1'b0, 8'h01);
    while (cpu_reset) step(1);
    no_drive(100, "R8");

    // R9 / R7: long outside pulse
    ext_low = 1'b1;
    step(1);
    chk(pin_sync == 1'b1, "R9", "pin_sync after one edge", pin_sync, 1);
    step(1);
    chk(pin_sync == 1'b0, "R9", "pin_sync after two edges", pin_sync, 0);
    chk(pin_drive_n == 1'b1, "R7", "no drive yet", pin_drive_n, 1);
    step(1);
    chk(pin_drive_n == 1'b0, "R7", "drive after sync low", pin_drive_n, 0);
    chk(cpu_reset == 1'b1, "R7", "cpu_reset up", cpu_reset, 1);
    step(297);
    chk(cpu_reset == 1'b1, "R7", "held while pad low", cpu_reset, 1);
    chk(rst_src == 2'd2, "R7", "source outside", rst_src, 2);
    ext_low = 1'b0;
    step(2);
    chk(cpu_reset == 1'b1, "R7", "still held", cpu_reset, 1);
    step(1);
    chk(cpu_reset == 1'b0, "R7", "released", cpu_reset, 0);
    chk(reset_vector == 16'hFFFE, "R7", "vector outside", reset_vector, 16'hFFFE);

    // R7: short outside pulse is reported as watchdog
    ext_low = 1'b1;
    step(20);
    ext_low = 1'b0;
    for (int i = 0; i < 400 && cpu_reset; i++) step(1);
    chk(cpu_reset == 1'b0, "R7", "short pulse released", cpu_reset, 0);
    chk(rst_src == 2'd1, "R7", "short pulse source", rst_src, 1);
    chk(reset_vector == 16'hFFFA, "R7", "short pulse vector", reset_vector, 16'hFFFA);

    // R6: slow-rising pad after watchdog drive
    cap_delay = 100;
    wr(1'b0, 8'h01);
    run_seq(tmo(1), "R6", 2);
    cap_delay = 20;
    wr(1'b0, 8'h02);
    run_seq(tmo(2), "R6", 1);
    cap_delay = 0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule